// File: doc/BRIEF.md
# Significance-Linked Cluster Symbol Encoder

This block walks a square pyramid of quantized wavelet coefficients and turns it into a stream of shape symbols. It looks for coefficients that are not zero. The first such coefficient found in scan order becomes the seed of a cluster, and its position is sent out. The cluster then grows through the 8-neighbourhood inside the same subband. Insignificant coefficients on the cluster border produce a ZERO symbol. A significant coefficient that owns a group of four children on the next finer scale produces a LINK symbol and queues that child group. Queued child groups are processed in arrival order after the current cluster has been fully expanded. Every significant coefficient that is encoded is also placed on a second stream, for a later magnitude coder.

The coefficients sit in an external memory that the block reads through a combinational port. A pulse on `start` launches one pass over the whole image. `busy` stays high until the last symbol has been accepted. Both outputs are valid/ready streams. A word is transferred on a rising edge where valid and ready are both high. While valid is high and ready is low, the word is held unchanged. Back-pressure on the symbol stream stalls the walk. Back-pressure on the significant-coefficient stream stalls the walk only once that queue is full. Either stream can therefore be slow without reordering the other.

Top module: `scl_encoder`

## Requirements
- R1: The coefficient at column x, row y is read at address y*N+x. Seeds are sought at the coarsest scale in the subband order low-low, then right (x offset), then lower (y offset), then diagonal. Each finer scale visits only the right, lower and diagonal subbands. Inside a subband, the order is left to right and then top to bottom.
- R2: A nonzero coefficient that has not yet been encoded, met by the scan, produces a SEED symbol carrying its position, followed at once by its sign symbol.
- R3: Symbol codes on `sym_kind` are: 0 SEED, 1 POS, 2 NEG, 3 ZERO, 4 LINK. A coefficient is significant when it is nonzero. POS is sent for a positive coefficient and NEG for a negative one. No other code appears.
- R4: A significant coefficient outside the low-low band, with x < N/2 and y < N/2, sends LINK (carrying its own position) right after its sign symbol. This queues the child group at (2x, 2y). No other coefficient sends LINK.
- R5: After a coefficient's sign (and LINK, if any), its neighbours inside the same subband are examined depth-first, in the order (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1). An unencoded zero neighbour sends ZERO. An unencoded significant neighbour is encoded and expanded before the next neighbour is examined.
- R6: Once a cluster is exhausted, the queued child groups are taken first-in first-out. Each group visits its four positions in the order (x,y), (x,y+1), (x+1,y), (x+1,y+1): an unencoded zero sends ZERO, and an unencoded significant one is encoded and expanded. Groups queued meanwhile are served before the scan resumes.
- R7: Each coefficient produces at most one of POS, NEG or ZERO during a pass.
- R8: Every POS or NEG coefficient appears on the significant-coefficient stream, in the same order as the sign symbols.
- R9: While `sym_valid` is high and `sym_ready` is low, `sym_kind`, `sym_x` and `sym_y` hold their values and valid stays high.
- R10: While `lsc_valid` is high and `lsc_ready` is low, `lsc_x` and `lsc_y` hold their values and valid stays high. Holding `lsc_ready` low does not stop the symbol stream until that queue is full.
- R11: `start` is ignored while `busy` is high. `busy` falls only after the last symbol of a pass has been accepted, and no symbol is valid while `busy` is low.
- R12: After reset, `busy`, `sym_valid` and `lsc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| busy | output | 1 | Pass in progress or symbol still pending |
| coef_addr | output | 2*L2N | Coefficient read address, row-major |
| coef_val | input | COEF_W | Signed coefficient at `coef_addr`, same cycle |
| sym_valid | output | 1 | Symbol stream valid |
| sym_ready | input | 1 | Symbol stream ready |
| sym_kind | output | 3 | Symbol code |
| sym_x | output | L2N | Column of the symbol's coefficient |
| sym_y | output | L2N | Row of the symbol's coefficient |
| lsc_valid | output | 1 | Significant-coefficient stream valid |
| lsc_ready | input | 1 | Significant-coefficient stream ready |
| lsc_x | output | L2N | Column of a significant coefficient |
| lsc_y | output | L2N | Row of a significant coefficient |

## Verification
Two functions can fall in the same cycle. A sign step pushes a new entry into the significant-coefficient queue while the consumer pops its head. In the same cycle, the symbol register can be reloaded on the edge that accepts its previous word. Holding both ready inputs high over dense random images makes both coincidences happen on most cycles. Random ready patterns and a phase with the coefficient stream blocked move the coincidences around. The scoreboard judges each case: a lost, doubled or reordered item on either stream shows up as a mismatch against the queue the bench model built independently.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [2:0] {
    SYM_SEED = 3'd0,
    SYM_POS  = 3'd1,
    SYM_NEG  = 3'd2,
    SYM_ZERO = 3'd3,
    SYM_LINK = 3'd4
  } sym_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SIGN,
    ST_LINK,
    ST_EXPAND,
    ST_CHILD,
    ST_POST
  } enc_state_t;

  // neighbour offsets in raster order around the centre
  function automatic int nb_dx(input logic [3:0] k);
    case (k)
      4'd0, 4'd3, 4'd5: return -1;
      4'd1, 4'd6:       return 0;
      default:          return 1;
    endcase
  endfunction

  function automatic int nb_dy(input logic [3:0] k);
    case (k)
      4'd0, 4'd1, 4'd2: return -1;
      4'd3, 4'd4:       return 0;
      default:          return 1;
    endcase
  endfunction

endpackage

// File: rtl/scl_fifo.sv
module scl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (int'(count) == DEPTH);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop)
        rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)
        count <= count + 1'b1;
      else if (do_pop && !do_push)
        count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/scl_stack.sv
module scl_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] top_idx;

  assign empty   = (sp == '0);
  assign top_idx = empty ? '0 : sp - 1'b1;
  assign top     = mem[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else if (push && int'(sp) < DEPTH) begin
      mem[sp] <= push_data;
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end
endmodule

// File: rtl/scl_encoder.sv
module scl_encoder
  import scl_pkg::*;
#(
  parameter int L2N    = 3,
  parameter int LEVELS = 2,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic [2*L2N-1:0]  coef_addr,
  input  logic [COEF_W-1:0] coef_val,
  output logic              sym_valid,
  input  logic              sym_ready,
  output logic [2:0]        sym_kind,
  output logic [L2N-1:0]    sym_x,
  output logic [L2N-1:0]    sym_y,
  output logic              lsc_valid,
  input  logic              lsc_ready,
  output logic [L2N-1:0]    lsc_x,
  output logic [L2N-1:0]    lsc_y
);
  localparam int N    = 1 << L2N;
  localparam int NC   = N * N;
  localparam int S    = N >> LEVELS;
  localparam int HALF = N / 2;
  localparam int NGRP = HALF * HALF;
  localparam int LVW  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int CRW  = 2 * L2N;
  localparam int FRW  = CRW + 4;

  enc_state_t st;
  logic [NC-1:0]    enc_map;
  logic [L2N-1:0]   cx, cy, gx, gy;
  logic [3:0]       ck;
  logic [2:0]       gj;
  logic             in_child, scan_done;
  logic [LVW-1:0]   s_lvl, n_lvl;
  logic [1:0]       s_band, n_band;
  logic [L2N-1:0]   s_r, s_c, n_r, n_c;
  logic [L2N-1:0]   scan_x, scan_y, nx, ny, chx, chy;
  logic             scan_last, nb_in, has_kids;
  logic [CRW-1:0]   rd;
  logic             sig, neg, enc_bit, out_free;

  logic             emit, mark;
  sym_kind_t        e_kind;
  logic [L2N-1:0]   e_x, e_y;
  logic             stk_push, stk_pop, stk_empty;
  logic [FRW-1:0]   stk_top;
  logic             lcc_push, lcc_pop, lcc_empty, lcc_full;
  logic [CRW-1:0]   lcc_head;
  logic             lsc_push, lsc_full, lsc_empty;
  logic [CRW-1:0]   lsc_head;

  // scan position and successor
  always_comb begin
    int sz, xi, yi;
    sz = S << s_lvl;
    xi = int'(s_c) + (s_band[0] ? sz : 0);
    yi = int'(s_r) + (s_band[1] ? sz : 0);
    scan_x = xi[L2N-1:0];
    scan_y = yi[L2N-1:0];
    scan_last = (int'(s_lvl) == LEVELS - 1) && (s_band == 2'd3) &&
                (int'(s_r) == sz - 1) && (int'(s_c) == sz - 1);
    n_c = s_c; n_r = s_r; n_band = s_band; n_lvl = s_lvl;
    if (int'(s_c) == sz - 1) begin
      n_c = '0;
      if (int'(s_r) == sz - 1) begin
        n_r = '0;
        if (s_band == 2'd3) begin
          n_band = 2'd1;
          n_lvl  = s_lvl + 1'b1;
        end else begin
          n_band = s_band + 2'd1;
        end
      end else begin
        n_r = s_r + 1'b1;
      end
    end else begin
      n_c = s_c + 1'b1;
    end
  end

  // subband of the current coefficient and the neighbour under test
  always_comb begin
    int m, bsz, bx0, by0, nxi, nyi;
    m   = (cx > cy) ? int'(cx) : int'(cy);
    bsz = S;
    for (int l = 1; l < LEVELS; l++)
      if (m >= (S << l)) bsz = S << l;
    bx0 = (int'(cx) >= bsz) ? bsz : 0;
    by0 = (int'(cy) >= bsz) ? bsz : 0;
    nxi = int'(cx) + nb_dx(ck);
    nyi = int'(cy) + nb_dy(ck);
    nb_in = (ck < 4'd8) && nxi >= bx0 && nxi < bx0 + bsz &&
            nyi >= by0 && nyi < by0 + bsz;
    nx = nxi[L2N-1:0];
    ny = nyi[L2N-1:0];
    has_kids = (int'(cx) >= S || int'(cy) >= S) &&
               int'(cx) < HALF && int'(cy) < HALF;
  end

  assign chx = gx + {{(L2N-1){1'b0}}, gj[1]};
  assign chy = gy + {{(L2N-1){1'b0}}, gj[0]};

  always_comb begin
    case (st)
      ST_SCAN:   rd = {scan_y, scan_x};
      ST_EXPAND: rd = {ny, nx};
      ST_CHILD:  rd = {chy, chx};
      default:   rd = {cy, cx};
    endcase
  end

  assign coef_addr = rd;
  assign sig       = (coef_val != '0);
  assign neg       = coef_val[COEF_W-1];
  assign enc_bit   = enc_map[rd];
  assign out_free  = !sym_valid || sym_ready;

  // per-state actions
  always_comb begin
    emit = 1'b0; mark = 1'b0; e_kind = SYM_SEED; e_x = cx; e_y = cy;
    stk_push = 1'b0; stk_pop = 1'b0; lcc_push = 1'b0; lcc_pop = 1'b0;
    lsc_push = 1'b0;
    case (st)
      ST_SCAN: if (out_free && sig && !enc_bit) begin
        emit = 1'b1; e_x = scan_x; e_y = scan_y;
      end
      ST_SIGN: if (out_free && !lsc_full) begin
        emit = 1'b1; mark = 1'b1; lsc_push = 1'b1;
        e_kind = neg ? SYM_NEG : SYM_POS;
      end
      ST_LINK: if (out_free) begin
        emit = 1'b1; e_kind = SYM_LINK; lcc_push = 1'b1;
      end
      ST_EXPAND: if (out_free) begin
        if (ck == 4'd8) stk_pop = !stk_empty;
        else if (nb_in && !enc_bit) begin
          if (sig) stk_push = 1'b1;
          else begin
            emit = 1'b1; mark = 1'b1; e_kind = SYM_ZERO; e_x = nx; e_y = ny;
          end
        end
      end
      ST_CHILD: if (out_free && !gj[2] && !enc_bit && !sig) begin
        emit = 1'b1; mark = 1'b1; e_kind = SYM_ZERO; e_x = chx; e_y = chy;
      end
      ST_POST: lcc_pop = !in_child && !lcc_empty;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      enc_map <= '0;
      {cx, cy, ck, gx, gy, gj} <= '0;
      {in_child, scan_done} <= 2'b00;
      {s_lvl, s_band, s_r, s_c} <= '0;
    end else begin
      if (mark) enc_map[rd] <= 1'b1;
      case (st)
        ST_IDLE: if (start && !sym_valid) begin
          enc_map <= '0;
          {s_lvl, s_band, s_r, s_c} <= '0;
          scan_done <= 1'b0;
          in_child <= 1'b0;
          st <= ST_SCAN;
        end
        ST_SCAN: if (out_free) begin
          if (sig && !enc_bit) begin
            cx <= scan_x; cy <= scan_y; ck <= '0;
            scan_done <= scan_last;
            st <= ST_SIGN;
          end else if (scan_last) begin
            st <= ST_IDLE;
          end
          if (!scan_last) begin
            s_c <= n_c; s_r <= n_r; s_band <= n_band; s_lvl <= n_lvl;
          end
        end
        ST_SIGN: if (out_free && !lsc_full)
          st <= has_kids ? ST_LINK : ST_EXPAND;
        ST_LINK: if (out_free) st <= ST_EXPAND;
        ST_EXPAND: if (out_free) begin
          if (ck == 4'd8) begin
            if (!stk_empty) {cx, cy, ck} <= stk_top;
            else st <= ST_POST;
          end else if (nb_in && !enc_bit && sig) begin
            cx <= nx; cy <= ny; ck <= '0;
            st <= ST_SIGN;
          end else begin
            ck <= ck + 4'd1;
          end
        end
        ST_CHILD: if (out_free) begin
          if (gj[2]) begin
            in_child <= 1'b0;
            st <= ST_POST;
          end else begin
            gj <= gj + 3'd1;
            if (!enc_bit && sig) begin
              cx <= chx; cy <= chy; ck <= '0;
              st <= ST_SIGN;
            end
          end
        end
        ST_POST: begin
          if (in_child) st <= ST_CHILD;
          else if (!lcc_empty) begin
            {gx, gy} <= lcc_head;
            gj <= '0;
            in_child <= 1'b1;
            st <= ST_CHILD;
          end else st <= scan_done ? ST_IDLE : ST_SCAN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // registered symbol output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_kind  <= '0;
      sym_x     <= '0;
      sym_y     <= '0;
    end else if (emit) begin
      sym_valid <= 1'b1;
      sym_kind  <= e_kind;
      sym_x     <= e_x;
      sym_y     <= e_y;
    end else if (sym_ready) begin
      sym_valid <= 1'b0;
    end
  end

  assign busy = (st != ST_IDLE) || sym_valid;

  scl_stack #(.W(FRW), .DEPTH(NC)) u_stack (
    .clk(clk), .rst_n(rst_n),
    .push(stk_push), .push_data({cx, cy, ck + 4'd1}),
    .pop(stk_pop), .top(stk_top), .empty(stk_empty)
  );

  scl_fifo #(.W(CRW), .DEPTH(NGRP)) u_lcc (
    .clk(clk), .rst_n(rst_n),
    .push(lcc_push), .push_data({cx[L2N-2:0], 1'b0, cy[L2N-2:0], 1'b0}),
    .pop(lcc_pop), .head(lcc_head), .empty(lcc_empty), .full(lcc_full)
  );

  scl_fifo #(.W(CRW), .DEPTH(NC)) u_lsc (
    .clk(clk), .rst_n(rst_n),
    .push(lsc_push), .push_data({cx, cy}),
    .pop(lsc_ready), .head(lsc_head), .empty(lsc_empty), .full(lsc_full)
  );

  assign lsc_valid = !lsc_empty;
  assign {lsc_x, lsc_y} = lsc_head;

endmodule

// File: rtl/scl_encoder_chk.sv
module scl_encoder_chk #(
  parameter int L2N    = 3,
  parameter int LEVELS = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           sym_valid,
  input logic           sym_ready,
  input logic [2:0]     sym_kind,
  input logic [L2N-1:0] sym_x,
  input logic [L2N-1:0] sym_y,
  input logic           lsc_valid,
  input logic           lsc_ready,
  input logic [L2N-1:0] lsc_x,
  input logic [L2N-1:0] lsc_y
);
  localparam int N    = 1 << L2N;
  localparam int S    = N >> LEVELS;
  localparam int HALF = N / 2;

  assert_sym_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ready |=> sym_valid && $stable(sym_kind) &&
                                $stable(sym_x) && $stable(sym_y));

  assert_lsc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lsc_valid && !lsc_ready |=> lsc_valid && $stable(lsc_x) && $stable(lsc_y));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> sym_kind <= 3'd4);

  assert_link_parent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_kind == 3'd4 |->
      int'(sym_x) < HALF && int'(sym_y) < HALF &&
      (int'(sym_x) >= S || int'(sym_y) >= S));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sym_valid);
endmodule

bind scl_encoder scl_encoder_chk #(.L2N(L2N), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_kind(sym_kind),
  .sym_x(sym_x), .sym_y(sym_y),
  .lsc_valid(lsc_valid), .lsc_ready(lsc_ready), .lsc_x(lsc_x), .lsc_y(lsc_y)
);

// File: tb/scl_encoder_tb.sv
module scl_encoder_tb;
  localparam int L2N = 3, LEV = 2, CW = 8;
  localparam int N = 1 << L2N, SS = N >> LEV, HALF = N / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, sym_valid, lsc_valid;
  logic sym_ready = 1'b0, lsc_ready = 1'b0;
  logic [2*L2N-1:0] coef_addr;
  logic [CW-1:0] coef_val;
  logic [2:0] sym_kind;
  logic [L2N-1:0] sym_x, sym_y, lsc_x, lsc_y;

  logic signed [CW-1:0] mem [N*N];
  int checks = 0, fails = 0;
  int sym_mode = 0, lsc_mode = 0;
  string tag = "R12";
  int exp_sym[$], exp_lsc[$], lq_x[$], lq_y[$];
  bit menc [N*N];
  bit sym_hold = 0, lsc_hold = 0;
  int sym_held, lsc_held;

  always #10 clk = ~clk;
  assign coef_val = mem[coef_addr];

  scl_encoder #(.L2N(L2N), .LEVELS(LEV), .COEF_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .coef_addr(coef_addr), .coef_val(coef_val),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_kind(sym_kind),
    .sym_x(sym_x), .sym_y(sym_y),
    .lsc_valid(lsc_valid), .lsc_ready(lsc_ready), .lsc_x(lsc_x), .lsc_y(lsc_y)
  );

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic int pk(input int k, input int x, input int y);
    return k * 4096 + x * 64 + y;
  endfunction

  // ---------------- reference model, built from the requirements ----------
  function automatic bit msig(input int x, input int y);
    return mem[y*N+x] != 0;
  endfunction

  task automatic m_sign(input int x, input int y);
    exp_sym.push_back(pk(mem[y*N+x] < 0 ? 2 : 1, x, y));
    exp_lsc.push_back(x * 64 + y);
    menc[y*N+x] = 1;
    if ((x >= SS || y >= SS) && x < HALF && y < HALF) begin   // R4
      exp_sym.push_back(pk(4, x, y));
      lq_x.push_back(2 * x);
      lq_y.push_back(2 * y);
    end
  endtask

  task automatic m_cluster(input int x0, input int y0);
    int fx[$], fy[$], fk[$];
    int cx = x0, cy = y0, ck = 0;
    int ddx[8] = '{-1, 0, 1, -1, 1, -1, 0, 1};
    int ddy[8] = '{-1, -1, -1, 0, 0, 1, 1, 1};
    m_sign(x0, y0);
    while (1) begin
      if (ck == 8) begin
        if (fx.size() == 0) break;
        cx = fx.pop_back(); cy = fy.pop_back(); ck = fk.pop_back();
      end else begin
        int m, bs, bx, by, nx, ny;
        m = (cx > cy) ? cx : cy;
        bs = SS;
        for (int l = 1; l < LEV; l++) if (m >= (SS << l)) bs = SS << l;
        bx = (cx >= bs) ? bs : 0;
        by = (cy >= bs) ? bs : 0;
        nx = cx + ddx[ck]; ny = cy + ddy[ck];
        ck++;
        if (nx >= bx && nx < bx + bs && ny >= by && ny < by + bs && !menc[ny*N+nx]) begin
          if (msig(nx, ny)) begin
            fx.push_back(cx); fy.push_back(cy); fk.push_back(ck);
            m_sign(nx, ny);
            cx = nx; cy = ny; ck = 0;
          end else begin
            exp_sym.push_back(pk(3, nx, ny));
            menc[ny*N+nx] = 1;
          end
        end
      end
    end
  endtask

  task automatic m_children();
    while (lq_x.size() > 0) begin
      int gx, gy;
      gx = lq_x.pop_front(); gy = lq_y.pop_front();
      for (int j = 0; j < 4; j++) begin
        int px, py;
        px = gx + (j >> 1); py = gy + (j & 1);
        if (!menc[py*N+px]) begin
          if (msig(px, py)) m_cluster(px, py);
          else begin
            exp_sym.push_back(pk(3, px, py));
            menc[py*N+px] = 1;
          end
        end
      end
    end
  endtask

  task automatic m_run();
    for (int i = 0; i < N*N; i++) menc[i] = 0;
    for (int lv = 0; lv < LEV; lv++) begin
      int s;
      s = SS << lv;
      for (int b = (lv == 0) ? 0 : 1; b < 4; b++)
        for (int r = 0; r < s; r++)
          for (int c = 0; c < s; c++) begin
            int x, y;
            x = c + ((b & 1) ? s : 0);
            y = r + ((b & 2) ? s : 0);
            if (msig(x, y) && !menc[y*N+x]) begin
              exp_sym.push_back(pk(0, x, y));
              m_cluster(x, y);
              m_children();
            end
          end
    end
  endtask

  // ---------------- monitor / scoreboard ---------------------------------
  always @(negedge clk) if (rst_n) begin
    if (sym_hold) chk(sym_valid && pk(sym_kind, sym_x, sym_y) == sym_held,
                      "R9 held symbol", pk(sym_kind, sym_x, sym_y), sym_held);
    if (lsc_hold) chk(lsc_valid && (lsc_x * 64 + lsc_y) == lsc_held,
                      "R10 held coefficient", lsc_x * 64 + lsc_y, lsc_held);
    sym_ready = (sym_mode == 0) ? 1'b1 : (sym_mode == 1) ? 1'($urandom % 2) : 1'b0;
    lsc_ready = (lsc_mode == 0) ? 1'b1 : (lsc_mode == 1) ? 1'($urandom % 2) : 1'b0;
    if (sym_valid && sym_ready) begin
      if (exp_sym.size() == 0) chk(0, {tag, " extra symbol"}, pk(sym_kind, sym_x, sym_y), -1);
      else begin
        int e;
        e = exp_sym.pop_front();
        chk(pk(sym_kind, sym_x, sym_y) == e, {tag, " symbol"}, pk(sym_kind, sym_x, sym_y), e);
      end
    end
    if (lsc_valid && lsc_ready) begin
      if (exp_lsc.size() == 0) chk(0, "R8 extra coefficient", lsc_x * 64 + lsc_y, -1);
      else begin
        int e;
        e = exp_lsc.pop_front();
        chk((lsc_x * 64 + lsc_y) == e, "R8 coefficient", lsc_x * 64 + lsc_y, e);
      end
    end
    sym_hold = sym_valid && !sym_ready;
    sym_held = pk(sym_kind, sym_x, sym_y);
    lsc_hold = lsc_valid && !lsc_ready;
    lsc_held = lsc_x * 64 + lsc_y;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input bit need_lsc);
    int n = 0;
    @(negedge clk);
    while ((busy || exp_sym.size() != 0 || (need_lsc && exp_lsc.size() != 0)) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, {tag, " watchdog"}, n, 20000);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < N*N; i++) mem[i] = '0;
  endtask

  task automatic random_mem(input int density);
    for (int i = 0; i < N*N; i++)
      mem[i] = (($urandom % 100) < density) ? CW'(int'($urandom % 7) - 3) : '0;
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R12: state after reset
    chk(!busy, "R12 busy", busy, 0);
    chk(!sym_valid, "R12 sym_valid", sym_valid, 0);
    chk(!lsc_valid, "R12 lsc_valid", lsc_valid, 0);
    rst_n = 1'b1;

    // all-zero image: nothing is emitted (R2)
    tag = "R2"; pulse_start(); wait_done(1);
    chk(exp_sym.size() == 0 && !sym_valid, "R2 empty image", sym_valid, 0);

    // single low-low coefficient, hand-built expectation (R2, R3, R5, R7)
    tag = "R2/R3/R7"; clear_mem(); mem[0*N+1] = 8'sd5;
    exp_sym = '{pk(0,1,0), pk(1,1,0), pk(3,0,0), pk(3,0,1), pk(3,1,1)};
    exp_lsc = '{1*64+0};
    pulse_start(); wait_done(1);

    // link to a child group, hand-built expectation (R4, R6, R3 NEG)
    tag = "R4/R6/R3"; clear_mem(); mem[0*N+2] = -8'sd3; mem[0*N+4] = 8'sd7;
    exp_sym = '{pk(0,2,0), pk(2,2,0), pk(4,2,0), pk(3,3,0), pk(3,2,1), pk(3,3,1),
                pk(1,4,0), pk(3,5,0), pk(3,4,1), pk(3,5,1)};
    exp_lsc = '{2*64+0, 4*64+0};
    pulse_start(); wait_done(1);

    // dense random, both streams always ready, second start ignored (R1, R5, R11)
    tag = "R1/R5/R11"; random_mem(45); m_run();
    pulse_start();
    repeat (8) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done(1);
    repeat (3) @(negedge clk);
    chk(!busy && !sym_valid, "R11 idle after pass", busy, 0);

    // random images under random back-pressure (R9, R10, R6, R8)
    for (int t = 0; t < 4; t++) begin
      tag = "R6/R9"; sym_mode = 1; lsc_mode = 1;
      random_mem(20 + 15 * t); m_run();
      pulse_start(); wait_done(1);
    end

    // coefficient stream blocked: symbols still flow (R10)
    tag = "R10"; sym_mode = 0; lsc_mode = 2;
    random_mem(30); m_run();
    pulse_start(); wait_done(0);
    chk(exp_sym.size() == 0, "R10 symbols drained while blocked", exp_sym.size(), 0);
    lsc_mode = 0; tag = "R8";
    wait_done(1);
    chk(exp_lsc.size() == 0, "R8 coefficients drained", exp_lsc.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule